// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block sequences the two gate enables of one synchronous-buck half-bridge from a single PWM command. When PWM goes high, the low-side switch is released first. The high-side switch is enabled only after the low-side gate is reported below threshold and a programmable delay has elapsed. When PWM goes low, the high-side switch is released first. The low-side switch is enabled after the switch node is reported low and a short delay has elapsed. If that report never arrives, the low side is enabled when a longer backup timer expires. The backup timer starts once the high-side gate-to-source voltage is reported as collapsed.

Three comparator results reach the block as digital flags: low-side gate low, switch node low, and high-side gate low. An active-high drive-allow input, the inverse of an output-disable pin, holds both enables low when it is deasserted. PWM and drive-allow pass through a synchronizer chain. The sense flags can optionally pass through one as well. Every delay is a cycle count set by a parameter.

Top module: `adt_gate_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, both `hs_en` and `ls_en` are 0. The controller leaves reset in its disabled state.
- R2: In steady operation, `hs_en` is 1 only while the synchronized PWM was high on the previous cycle. `ls_en` is 1 only while it was low.
- R3: When `drive_allow` falls, both enables are 0 by the SYNC_STAGES+1-th clock edge after the change. They stay 0 regardless of PWM or the sense flags for as long as `drive_allow` is low.
- R4: A PWM rise drops `ls_en` on the SYNC_STAGES+1-th edge. `hs_en` stays 0 until `lsg_low` is sampled high. `hs_en` then rises on the HS_DLY-th edge, counting the edge that sampled the flag as the first.
- R5: A PWM fall drops `hs_en` on the SYNC_STAGES+1-th edge. `ls_en` stays 0 until `sw_low` is sampled high. `ls_en` then rises on the LS_DLY-th edge, counting the sampling edge as the first.
- R6: After a high-side turn-off, if `hsg_low` is sampled high and `sw_low` stays low, `ls_en` rises on the LS_TMO-th edge, counting the sampling edge as the first. LS_TMO is larger than LS_DLY.
- R7: `hs_en` and `ls_en` are never 1 in the same cycle. An enable rises only if the opposite enable was 0 on the previous cycle.
- R8: A PWM edge that reverses the command during a turn-on wait abandons the wait. The switch that was being waited for never turns on, and the other side's turn-on sequence starts with its counters cleared.
- R9: When `drive_allow` rises, or reset is released with it high, the controller stays disabled for SYNC_STAGES+EN_LAT edges. It then enters the wait sequence that PWM selects, with both enables still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | Asynchronous PWM command, 1 = high side on |
| drive_allow | input | 1 | Asynchronous enable, 0 forces both gates off |
| lsg_low | input | 1 | Low-side gate is below its turn-off threshold |
| sw_low | input | 1 | Switch node is below its threshold |
| hsg_low | input | 1 | High-side gate-to-source is below its threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The embedded assertions check these properties on every cycle:
- the two enables are never high together, and each rises only after the other has been low;
- each enable agrees with the previous synchronized PWM level;
- a deasserted drive-allow clears both outputs one cycle later;
- the backup timer stays in range.

The exact edge counts cannot be expressed as cycle-local properties, so only the directed scenarios show them. Those counts are the synchronizer latency, the two adaptive delays, the backup timeout, the enable latency, and the abandonment of a wait when PWM reverses. A randomized phase drives a simple half-bridge model to stress the overlap rule under arbitrary edge timing, including a switch node that never falls.

// File: rtl/adt_pkg.sv
// Shared types for the adaptive dead-time gate controller.
// Assumes: nothing beyond standard SystemVerilog.
package adt_pkg;

    // Controller states; only GS_HS_ON and GS_LS_ON drive a gate.
    typedef enum logic [2:0] {
        GS_DISABLED,
        GS_LS_ON,
        GS_WAIT_LS_OFF,
        GS_HS_ON,
        GS_WAIT_HS_OFF
    } adt_state_e;

endpackage

// File: rtl/adt_sync.sv
// Multi-flop synchronizer for a small bus of independent level signals.
// Assumes: each bit is a slow level; STAGES = 0 gives a plain wire.
module adt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (STAGES == 0) begin : g_bypass
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign q = d;
    end else begin : g_chain
        logic [W-1:0] pipe [STAGES];

        // Shift the input through the flop chain; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
                pipe[0] <= d;
                for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
        end

        assign q = pipe[STAGES-1];
    end

endmodule

// File: rtl/adt_fsm.sv
// Sequencing core: turns synchronized PWM and sense flags into gate enables
// with adaptive dead time and a backup low-side timeout.
// Assumes: all inputs are synchronous to clk; HS_DLY, LS_DLY, EN_LAT >= 1;
// LS_TMO > LS_DLY.
module adt_fsm
    import adt_pkg::*;
#(
    parameter int EN_LAT = 2,
    parameter int HS_DLY = 2,
    parameter int LS_DLY = 2,
    parameter int LS_TMO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_s,
    input  logic allow_s,
    input  logic lsg_s,
    input  logic sw_s,
    input  logic hsg_s,
    output logic hs_q,
    output logic ls_q
);

    localparam int CMAX_A = (EN_LAT > HS_DLY) ? EN_LAT : HS_DLY;
    localparam int CMAX   = (CMAX_A > LS_DLY) ? CMAX_A : LS_DLY;
    localparam int CW     = $clog2(CMAX + 1);
    localparam int TW     = $clog2(LS_TMO + 1);

    adt_state_e    st, nxt;
    logic [CW-1:0] cnt;
    logic [TW-1:0] tcnt;
    logic          arm, tarm;
    logic          cnt_inc, tmo_inc, arm_set, tarm_set, clr;
    logic          p_go, t_go, p_done, t_done;

    assign p_go   = arm || sw_s;
    assign t_go   = tarm || hsg_s;
    assign p_done = p_go && (cnt == CW'(LS_DLY - 1));
    assign t_done = t_go && (tcnt == TW'(LS_TMO - 1));

    // Next-state and counter-control decode; disable has top priority.
    always_comb begin
        nxt      = st;
        cnt_inc  = 1'b0;
        tmo_inc  = 1'b0;
        arm_set  = 1'b0;
        tarm_set = 1'b0;
        if (!allow_s) begin
            nxt = GS_DISABLED;
        end else begin
            unique case (st)
                GS_DISABLED: begin
                    if (cnt == CW'(EN_LAT - 1))
                        nxt = pwm_s ? GS_WAIT_LS_OFF : GS_WAIT_HS_OFF;
                    else
                        cnt_inc = 1'b1;
                end
                GS_LS_ON: begin
                    if (pwm_s) nxt = GS_WAIT_LS_OFF;
                end
                GS_WAIT_LS_OFF: begin
                    if (!pwm_s) begin
                        nxt = GS_WAIT_HS_OFF;
                    end else if (arm || lsg_s) begin
                        if (cnt == CW'(HS_DLY - 1)) begin
                            nxt = GS_HS_ON;
                        end else begin
                            cnt_inc = 1'b1;
                            arm_set = 1'b1;
                        end
                    end
                end
                GS_HS_ON: begin
                    if (!pwm_s) nxt = GS_WAIT_HS_OFF;
                end
                GS_WAIT_HS_OFF: begin
                    if (pwm_s) begin
                        nxt = GS_WAIT_LS_OFF;
                    end else if (p_done || t_done) begin
                        nxt = GS_LS_ON;
                    end else begin
                        cnt_inc  = p_go;
                        arm_set  = p_go;
                        tmo_inc  = t_go;
                        tarm_set = t_go;
                    end
                end
                default: nxt = GS_DISABLED;
            endcase
        end
    end

    assign clr = (nxt != st) || !allow_s;

    // State, delay counters, arm flags and registered gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= GS_DISABLED;
            cnt  <= '0;
            tcnt <= '0;
            arm  <= 1'b0;
            tarm <= 1'b0;
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            st   <= nxt;
            hs_q <= (nxt == GS_HS_ON);
            ls_q <= (nxt == GS_LS_ON);
            if (clr) begin
                cnt  <= '0;
                tcnt <= '0;
                arm  <= 1'b0;
                tarm <= 1'b0;
            end else begin
                if (cnt_inc)  cnt  <= cnt + 1'b1;
                if (tmo_inc)  tcnt <= tcnt + 1'b1;
                if (arm_set)  arm  <= 1'b1;
                if (tarm_set) tarm <= 1'b1;
            end
        end
    end

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_q && ls_q));

    // R7
    hs_bbm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q) |-> !$past(ls_q));

    // R7
    ls_bbm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_q) |-> !$past(hs_q));

    // R3
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !allow_s |=> (!hs_q && !ls_q));

    // R2
    hs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q |-> $past(pwm_s));

    // R2
    ls_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_q |-> !$past(pwm_s));

    // R6
    tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt < TW'(LS_TMO));

endmodule

// File: rtl/adt_gate_ctrl.sv
// Top of the adaptive dead-time gate controller for one half-bridge.
// Synchronizes PWM and drive-allow, optionally synchronizes the sense flags,
// and hands them to the sequencing core.
// Assumes: sense flags are comparator outputs already in the clk domain
// when SENSE_STAGES = 0.
module adt_gate_ctrl #(
    parameter int SYNC_STAGES  = 2,
    parameter int SENSE_STAGES = 0,
    parameter int EN_LAT       = 2,
    parameter int HS_DLY       = 2,
    parameter int LS_DLY       = 2,
    parameter int LS_TMO       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic drive_allow,
    input  logic lsg_low,
    input  logic sw_low,
    input  logic hsg_low,
    output logic hs_en,
    output logic ls_en
);

    logic [1:0] cmd_s;
    logic [2:0] sense_s;

    adt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_cmd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({drive_allow, pwm_in}),
        .q     (cmd_s)
    );

    adt_sync #(.W(3), .STAGES(SENSE_STAGES)) u_sense_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hsg_low, sw_low, lsg_low}),
        .q     (sense_s)
    );

    adt_fsm #(
        .EN_LAT (EN_LAT),
        .HS_DLY (HS_DLY),
        .LS_DLY (LS_DLY),
        .LS_TMO (LS_TMO)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_s   (cmd_s[0]),
        .allow_s (cmd_s[1]),
        .lsg_s   (sense_s[0]),
        .sw_s    (sense_s[1]),
        .hsg_s   (sense_s[2]),
        .hs_q    (hs_en),
        .ls_q    (ls_en)
    );

endmodule

// File: tb/adt_gate_ctrl_bench.sv
// Directed bench for the adaptive dead-time gate controller, default parameters.
module adt_gate_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0;
    logic drive_allow = 1'b1;
    logic lsg_low = 1'b0;
    logic sw_low = 1'b1;
    logic hsg_low = 1'b0;
    logic hs_en, ls_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adt_gate_ctrl u_adt_gate_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_in      (pwm_in),
        .drive_allow (drive_allow),
        .lsg_low     (lsg_low),
        .sw_low      (sw_low),
        .hsg_low     (hsg_low),
        .hs_en       (hs_en),
        .ls_en       (ls_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        tick(3);
        check("R1 hs in reset", hs_en, 1'b0);
        check("R1 ls in reset", ls_en, 1'b0);
        rst_n = 1'b1;
        tick(1);
        check("R1 ls after reset", ls_en, 1'b0);
        tick(4);
        check("R9 ls still off", ls_en, 1'b0);
        tick(1);
        check("R9 ls on after latency", ls_en, 1'b1);
        check("R2 hs off with pwm low", hs_en, 1'b0);
    endtask

    task automatic t_rise();
        pwm_in = 1'b1;
        tick(2);
        check("R4 ls held before sync", ls_en, 1'b1);
        tick(1);
        check("R4 ls dropped", ls_en, 1'b0);
        check("R4 hs not yet", hs_en, 1'b0);
        tick(4);
        check("R4 hs waits for lsg_low", hs_en, 1'b0);
        lsg_low = 1'b1;
        tick(1);
        check("R4 hs during delay", hs_en, 1'b0);
        tick(1);
        check("R4 hs on after delay", hs_en, 1'b1);
        check("R2 ls off with pwm high", ls_en, 1'b0);
        sw_low = 1'b0;
    endtask

    task automatic t_fall_primary();
        pwm_in = 1'b0;
        tick(2);
        check("R5 hs held before sync", hs_en, 1'b1);
        tick(1);
        check("R5 hs dropped", hs_en, 1'b0);
        tick(3);
        check("R5 ls waits for sw_low", ls_en, 1'b0);
        sw_low = 1'b1;
        tick(1);
        check("R5 ls during delay", ls_en, 1'b0);
        tick(1);
        check("R5 ls on after delay", ls_en, 1'b1);
        lsg_low = 1'b0;
    endtask

    task automatic t_fall_timeout();
        pwm_in = 1'b1;
        tick(3);
        check("R4 ls dropped again", ls_en, 1'b0);
        lsg_low = 1'b1;
        sw_low = 1'b0;
        tick(2);
        check("R4 hs on again", hs_en, 1'b1);
        pwm_in = 1'b0;
        tick(3);
        check("R6 hs dropped", hs_en, 1'b0);
        hsg_low = 1'b1;
        tick(15);
        check("R6 ls before timeout", ls_en, 1'b0);
        tick(1);
        check("R6 ls on at timeout", ls_en, 1'b1);
        lsg_low = 1'b0;
        sw_low = 1'b1;
        hsg_low = 1'b0;
    endtask

    task automatic t_cancel_rise();
        pwm_in = 1'b1;
        tick(3);
        check("R8 ls dropped", ls_en, 1'b0);
        tick(2);
        pwm_in = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            check("R8 hs stays off on cancel", hs_en, 1'b0);
        end
        tick(1);
        check("R8 ls back after cancel", ls_en, 1'b1);
    endtask

    task automatic t_cancel_fall();
        pwm_in = 1'b1;
        tick(3);
        lsg_low = 1'b1;
        tick(2);
        check("R8 hs on before cancel", hs_en, 1'b1);
        sw_low = 1'b0;
        pwm_in = 1'b0;
        tick(3);
        check("R8 hs dropped", hs_en, 1'b0);
        tick(2);
        pwm_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            check("R8 ls stays off on cancel", ls_en, 1'b0);
        end
        tick(1);
        check("R8 hs back after cancel", hs_en, 1'b1);
    endtask

    task automatic t_disable();
        drive_allow = 1'b0;
        tick(2);
        check("R3 hs held before sync", hs_en, 1'b1);
        tick(1);
        check("R3 hs forced off", hs_en, 1'b0);
        check("R3 ls forced off", ls_en, 1'b0);
        pwm_in = 1'b0;
        sw_low = 1'b1;
        hsg_low = 1'b1;
        lsg_low = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            check("R3 both off while disabled", hs_en | ls_en, 1'b0);
        end
    endtask

    task automatic t_enable();
        drive_allow = 1'b1;
        tick(5);
        check("R9 ls off during enable latency", ls_en, 1'b0);
        tick(1);
        check("R9 ls on after enable", ls_en, 1'b1);
        hsg_low = 1'b0;
        lsg_low = 1'b0;
    endtask

    task automatic t_random();
        int hs_off = 0;
        int ls_off = 0;
        bit sinking = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            tick(1);
            check("R7 no overlap", hs_en & ls_en, 1'b0);
            hs_off = hs_en ? 0 : hs_off + 1;
            ls_off = ls_en ? 0 : ls_off + 1;
            if (($urandom % 40) == 0) sinking = ~sinking;
            lsg_low = (ls_off >= 2);
            hsg_low = (hs_off >= 2);
            sw_low  = (hs_off >= 4) && !sinking;
            if (($urandom % 9) == 0) pwm_in = ~pwm_in;
            if (($urandom % 150) == 0) drive_allow = ~drive_allow;
        end
        drive_allow = 1'b1;
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall_primary();
        t_fall_timeout();
        t_cancel_rise();
        t_cancel_fall();
        t_disable();
        t_enable();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule